// File: doc/BRIEF.md
# Trimmed-Mean Sample Filter

This block reduces a stream of 12-bit readings into one filtered result per measurement. Each reading arrives with a valid strobe and a channel index. Each of four channels keeps its own running state. A 12-bit configuration word holds one 3-bit mode code per channel, and that code sets how many readings make up one measurement and how they are combined.

The simplest modes pass a reading straight through or take the mean of a pair. The trimmed modes are different. The block tracks the running sum, minimum and maximum of the readings collected so far. When the last reading of the measurement arrives, it removes one smallest and one largest value and divides the rest by a power of two using a right shift.

A result appears on a one-cycle strobe, together with the channel it belongs to. Channels may be interleaved freely, one reading per cycle.

Top module: `tmf_filter`

## Requirements
- R1: While reset is asserted and after it is released, `res_valid` is low until a measurement completes, and every channel starts with an empty measurement.
- R2: Mode code 0 in a channel's field ends a measurement at every reading, and the result equals that reading.
- R3: Mode code 1 collects two readings and returns their sum shifted right by one (truncating).
- R4: Mode codes 2, 3, 4 and 5 collect 4, 6, 10 and 18 readings respectively. They return (sum − minimum − maximum) shifted right by 1, 2, 3 and 4 bits, and the result lies between the minimum and maximum of the measurement.
- R5: Channel c takes its mode from `mode_cfg[3c+2:3c]` (channel 0 in bits 2:0, channel 3 in bits 11:9). Channels accumulate independently when their readings are interleaved.
- R6: Mode codes 6 and 7 behave exactly as mode code 0.
- R7: If a reading arrives for a channel whose mode code differs from the code in force at the start of its unfinished measurement, the earlier readings are discarded. That reading becomes the first of a new measurement under the new code.
- R8: `res_valid` rises in the cycle after the reading that completes a measurement, `res_chan` then carries that reading's channel, and `res_valid` is low in every other cycle.
- R9: When several readings share the extreme value, exactly one copy of the minimum and one copy of the maximum are removed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_cfg | input | 12 | Four 3-bit mode codes, channel c in bits 3c+2:3c |
| smp_valid | input | 1 | A reading is presented this cycle |
| smp_chan | input | 2 | Channel of the reading |
| smp_data | input | 12 | Reading value, unsigned |
| res_valid | output | 1 | One-cycle strobe: a measurement has finished |
| res_chan | output | 2 | Channel of the finished measurement |
| res_data | output | 12 | Filtered result |

## Verification
The assertions take for granted that `mode_cfg` is sampled in the same cycle as the reading it governs. They also assume that a channel's field is read with the value present at that edge, so the pass-through check compares against the code seen alongside the reading. The stimulus changes `mode_cfg` only between cycles, at the same point where it drives readings, and gives the bench model that same value. Random mode changes land mid-measurement on purpose, and the model applies the discard rule to them, so every result the bench expects follows from the configuration it actually presented.

// File: rtl/tmf_pkg.sv
package tmf_pkg;
    parameter int SAMPLE_W = 12;
    parameter int NUM_CH   = 4;
    parameter int MODE_W   = 3;
    parameter int MAX_N    = 18;

    localparam int CH_W  = $clog2(NUM_CH);
    localparam int CNT_W = $clog2(MAX_N + 1);
    localparam int SUM_W = SAMPLE_W + $clog2(MAX_N);
    localparam int SHF_W = 3;
    localparam int CFG_W = NUM_CH * MODE_W;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [SHF_W-1:0] shift;
        logic             trim;
    } mode_info_t;
endpackage

// File: rtl/tmf_mode_dec.sv
module tmf_mode_dec
    import tmf_pkg::*;
(
    input  logic [MODE_W-1:0] code,
    output mode_info_t        info
);
    always_comb begin
        info = '{count: CNT_W'(1), shift: '0, trim: 1'b0};
        case (code)
            3'd1: info = '{count: CNT_W'(2),  shift: SHF_W'(1), trim: 1'b0};
            3'd2: info = '{count: CNT_W'(4),  shift: SHF_W'(1), trim: 1'b1};
            3'd3: info = '{count: CNT_W'(6),  shift: SHF_W'(2), trim: 1'b1};
            3'd4: info = '{count: CNT_W'(10), shift: SHF_W'(3), trim: 1'b1};
            3'd5: info = '{count: CNT_W'(18), shift: SHF_W'(4), trim: 1'b1};
            default: info = '{count: CNT_W'(1), shift: '0, trim: 1'b0};
        endcase
    end
endmodule

// File: rtl/tmf_chan_acc.sv
module tmf_chan_acc
    import tmf_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                take,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [MODE_W-1:0]   mode,
    output logic                done,
    output logic [SAMPLE_W-1:0] result
);
    typedef struct packed {
        logic [CNT_W-1:0]    cnt;
        logic [MODE_W-1:0]   mode;
        logic [SUM_W-1:0]    sum;
        logic [SAMPLE_W-1:0] lo;
        logic [SAMPLE_W-1:0] hi;
    } acc_t;

    acc_t       st_d, st_q;
    mode_info_t info;

    logic                fresh;
    logic [CNT_W-1:0]    cnt_nx;
    logic [SUM_W-1:0]    sum_nx, kept;
    logic [SAMPLE_W-1:0] lo_nx, hi_nx;

    tmf_mode_dec u_dec (
        .code (mode),
        .info (info)
    );

    always_comb begin
        // a changed code restarts the measurement with this reading
        fresh  = (st_q.cnt == '0) || (st_q.mode != mode);
        cnt_nx = (fresh ? '0 : st_q.cnt) + CNT_W'(1);
        sum_nx = (fresh ? '0 : st_q.sum) + SUM_W'(sample);
        lo_nx  = (fresh || sample < st_q.lo) ? sample : st_q.lo;
        hi_nx  = (fresh || sample > st_q.hi) ? sample : st_q.hi;
        kept   = info.trim ? (sum_nx - SUM_W'(lo_nx) - SUM_W'(hi_nx)) : sum_nx;
        result = SAMPLE_W'(kept >> info.shift);
        done   = take && (cnt_nx == info.count);

        st_d = st_q;
        if (take) begin
            st_d.mode = mode;
            st_d.sum  = sum_nx;
            st_d.lo   = lo_nx;
            st_d.hi   = hi_nx;
            st_d.cnt  = done ? '0 : cnt_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_RESULT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result >= lo_nx) && (result <= hi_nx)); // R4

    AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < CNT_W'(MAX_N)); // R4
endmodule

// File: rtl/tmf_filter.sv
module tmf_filter
    import tmf_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [11:0]         mode_cfg,
    input  logic                smp_valid,
    input  logic [1:0]          smp_chan,
    input  logic [11:0]         smp_data,
    output logic                res_valid,
    output logic [1:0]          res_chan,
    output logic [11:0]         res_data
);
    typedef struct packed {
        logic                valid;
        logic [CH_W-1:0]     chan;
        logic [SAMPLE_W-1:0] data;
    } out_t;

    out_t                out_d, out_q;
    logic [NUM_CH-1:0]   done_vec;
    logic [SAMPLE_W-1:0] res_arr [NUM_CH];
    logic [MODE_W-1:0]   cur_mode;

    assign cur_mode = mode_cfg[smp_chan*MODE_W +: MODE_W];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        tmf_chan_acc u_acc (
            .clk    (clk),
            .rst_n  (rst_n),
            .take   (smp_valid && (smp_chan == CH_W'(c))),
            .sample (smp_data),
            .mode   (mode_cfg[c*MODE_W +: MODE_W]),
            .done   (done_vec[c]),
            .result (res_arr[c])
        );
    end

    always_comb begin
        out_d = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (done_vec[c]) begin
                out_d.valid = 1'b1;
                out_d.chan  = CH_W'(c);
                out_d.data  = res_arr[c];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign res_valid = out_q.valid;
    assign res_chan  = out_q.chan;
    assign res_data  = out_q.data;

    AST_SINGLE_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done_vec)); // R5

    AST_STROBE_AFTER_READING: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(smp_valid)); // R8

    AST_CHAN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> res_chan == $past(smp_chan)); // R8

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid && (cur_mode == 3'd0 || cur_mode > 3'd5)
        |=> res_valid && res_data == $past(smp_data)); // R2
endmodule

// File: tb/sim_tmf_filter.sv
module sim_tmf_filter;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] mode_cfg;
    logic        smp_valid;
    logic [1:0]  smp_chan;
    logic [11:0] smp_data;
    logic        res_valid;
    logic [1:0]  res_chan;
    logic [11:0] res_data;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    int ref_cnt  [4];
    int ref_mode [4];
    int ref_buf  [4][18];

    always #(CLK_PERIOD/2) clk = ~clk;

    tmf_filter u0 (
        .clk(clk), .rst_n(rst_n), .mode_cfg(mode_cfg),
        .smp_valid(smp_valid), .smp_chan(smp_chan), .smp_data(smp_data),
        .res_valid(res_valid), .res_chan(res_chan), .res_data(res_data)
    );

    function automatic int need(int m);
        case (m)
            1: return 2;  2: return 4;  3: return 6;
            4: return 10; 5: return 18; default: return 1;
        endcase
    endfunction

    function automatic int expect_val(int ch, int m);
        int sum = 0, lo = 4096, hi = -1, n = need(m);
        for (int i = 0; i < n; i++) begin
            sum += ref_buf[ch][i];
            if (ref_buf[ch][i] < lo) lo = ref_buf[ch][i];
            if (ref_buf[ch][i] > hi) hi = ref_buf[ch][i];
        end
        case (m)
            1: return sum >> 1;
            2: return (sum - lo - hi) >> 1;
            3: return (sum - lo - hi) >> 2;
            4: return (sum - lo - hi) >> 3;
            5: return (sum - lo - hi) >> 4;
            default: return sum;
        endcase
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(bit v, int ch, int s, string tag);
        bit ev = 1'b0;
        int er = 0;
        int m;
        smp_valid = v;
        smp_chan  = 2'(ch);
        smp_data  = 12'(s);
        m = int'(mode_cfg[ch*3 +: 3]);
        if (v) begin
            if (ref_cnt[ch] != 0 && ref_mode[ch] != m) ref_cnt[ch] = 0;
            ref_buf[ch][ref_cnt[ch]] = s;
            ref_cnt[ch]++;
            ref_mode[ch] = m;
            if (ref_cnt[ch] == need(m)) begin
                ev = 1'b1;
                er = expect_val(ch, m);
                ref_cnt[ch] = 0;
            end
        end
        @(negedge clk);
        check(res_valid == ev, {tag, " strobe"}, int'(res_valid), int'(ev));
        if (ev) begin
            check(res_chan == 2'(ch), {tag, " R8 channel"}, int'(res_chan), ch);
            check(res_data == 12'(er), {tag, " result"}, int'(res_data), er);
        end
    endtask

    function automatic logic [11:0] setf(logic [11:0] cfg, int ch, int m);
        logic [11:0] r = cfg;
        r[ch*3 +: 3] = 3'(m);
        return r;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int s_a, s_b;
        void'($urandom(32'd4242));
        for (int c = 0; c < 4; c++) begin ref_cnt[c] = 0; ref_mode[c] = 0; end
        rst_n = 1'b0; mode_cfg = '0; smp_valid = 1'b0; smp_chan = '0; smp_data = '0;
        repeat (3) @(negedge clk);
        check(res_valid == 1'b0, "R1 in reset", int'(res_valid), 0);
        rst_n = 1'b1;
        step(0, 0, 0, "R1");
        step(0, 1, 0, "R1");

        // R2 pass-through, channel 0
        step(1, 0, 123, "R2");
        step(1, 0, 4095, "R2");
        step(1, 0, 0, "R2");
        // R6 codes 6 and 7
        mode_cfg = setf(mode_cfg, 0, 6); step(1, 0, 777, "R6");
        mode_cfg = setf(mode_cfg, 0, 7); step(1, 0, 31, "R6");
        // R3 pair mean truncates
        mode_cfg = setf(mode_cfg, 1, 1);
        step(1, 1, 7, "R3"); step(1, 1, 8, "R3");
        step(1, 1, 4095, "R3"); step(0, 1, 0, "R3"); step(1, 1, 4094, "R3");
        // R9 equal values and repeated extremes
        mode_cfg = setf(mode_cfg, 2, 2);
        for (int i = 0; i < 4; i++) step(1, 2, 5, "R9");
        mode_cfg = setf(mode_cfg, 2, 3);
        step(1, 2, 1, "R9"); step(1, 2, 9, "R9"); step(1, 2, 9, "R9");
        step(1, 2, 1, "R9"); step(1, 2, 4, "R9"); step(1, 2, 6, "R9");
        // R4 longest mode with extremes
        mode_cfg = setf(mode_cfg, 3, 5);
        step(1, 3, 0, "R4"); step(1, 3, 4095, "R4");
        for (int i = 0; i < 16; i++) step(1, 3, 1000 + i * 3, "R4");
        mode_cfg = setf(mode_cfg, 3, 4);
        for (int i = 0; i < 10; i++) step(1, 3, 4095 - i * 50, "R4");
        // R7 mode change mid-measurement
        mode_cfg = setf(mode_cfg, 1, 2);
        step(1, 1, 10, "R7"); step(1, 1, 20, "R7");
        mode_cfg = setf(mode_cfg, 1, 1);
        step(1, 1, 30, "R7"); step(1, 1, 40, "R7");
        // R5 interleaved channels, field positions
        mode_cfg = 12'b000_011_010_001; // ch3=0, ch2=3, ch1=2, ch0=1
        for (int i = 0; i < 6; i++) begin
            step(1, 2, 100 * i + 3, "R5");
            step(1, 3, 50 + i, "R5");
            step(1, 1, 900 - 20 * i, "R5");
            step(1, 0, 11 * i, "R5");
        end
        // constrained random traffic
        for (int k = 0; k < 6000; k++) begin
            if ($urandom_range(0, 149) == 0) mode_cfg = 12'($urandom);
            s_a = int'($urandom_range(0, 3));
            s_b = ($urandom_range(0, 9) == 0) ? int'($urandom_range(0, 1)) * 4095
                                              : int'($urandom_range(0, 4095));
            step($urandom_range(0, 3) != 0, s_a, s_b, "R4/R7 random");
        end
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule